// File: doc/BRIEF.md
# Speculative L0 Filter Cache

This block is a small data cache placed between a core's load/store unit and its first-level cache. Any line fetched because of a speculative access is stored here and nowhere else, so nothing a speculative access brings in can change what the L1 holds. Each entry carries a committed flag and a code naming the level that supplied it. A line moves outward only after an instruction that used it reaches in-order commit. At that point the block writes the whole line through to the L1 and, if that source level prefetches, sends that level a prefetch notice. If the line has already been evicted when its instruction commits, the block asks the L1 to fetch it again.

The core looks up entries by virtual address. Fills and commits locate entries by physical address. This works because the set index is taken from address bits that both addresses share. Valid bits are kept in flip-flops apart from the line storage. Any protection-domain change therefore empties the whole cache in one cycle, with no write-back. Fills that were requested before such a change are identified by an epoch tag and discarded when they return.

Top module: `l0f_filter_cache`

## Requirements
- R1: A lookup presented in cycle t reports hit and the 512-bit line on lk_hit/lk_data after the next clock edge. It matches on virtual tag (address bits 31:9) within the set chosen by bits 8:6, ignoring offset bits 5:0. Virtual and physical addresses of one line share bits 8:6.
- R2: A fill with fill_spec=1 installs its line with the committed flag clear. A fill with fill_spec=0 installs it with the flag set, and a later commit of that line produces neither a write-through nor a re-request.
- R3: A commit whose physical line is resident with the flag clear sets the flag. One cycle later it pulses wt_valid with the line-aligned physical address and the stored line. The line stays resident, and a second commit of it produces no output.
- R4: A commit whose physical line is not resident pulses rereq_valid one cycle later with the line-aligned physical address, and pulses no write-through.
- R5: A fill of a new line takes the lowest-numbered invalid way of its set. When all four ways are valid, the victim is picked round-robin per set starting at way 0. An evicted line produces no write-through, whether committed or not.
- R6: A context switch, system call, domain switch or sandbox-entry flush clears every valid bit at the next edge, so any lookup in the following cycle misses.
- R7: A mispredict event flushes only while clr_on_misspec is 1; otherwise resident lines keep hitting.
- R8: A fill whose physical line is already resident overwrites that entry, even under a different virtual address. The old virtual address then misses, and no second copy is held.
- R9: A write-through of a line whose source code (0 = L1, 1 = L2, 2 = L3, 3 = memory) has its bit set in PF_MASK (default: codes 0 and 1) also pulses pf_valid with that code on pf_level. Other source codes give no notice.
- R10: cur_epoch increments by one (wrapping) on every flush. A fill whose fill_epoch differs from cur_epoch, or that arrives in a flush cycle, is discarded.
- R11: When a fill and a commit of the same physical line occur in the same cycle, the line is installed committed. The commit acts on the state before the fill, so it re-requests if the line was absent.
- R12: A lookup in the same cycle as a flush reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_data | output | 512 | Line data for a hit |
| fill_valid | input | 1 | Fill returning from the hierarchy |
| fill_vaddr | input | 32 | Virtual address of the filled line |
| fill_paddr | input | 32 | Physical address of the filled line |
| fill_spec | input | 1 | Fill was requested by a speculative access |
| fill_src | input | 2 | Level that supplied the line |
| fill_epoch | input | 2 | Epoch sampled when the miss was issued |
| fill_data | input | 512 | Line contents |
| cm_valid | input | 1 | A load or store reached commit |
| cm_paddr | input | 32 | Physical address used by the committing access |
| evt_ctx_switch | input | 1 | Context switch |
| evt_syscall | input | 1 | System call entry |
| evt_domain_switch | input | 1 | Protection-domain switch |
| evt_sandbox_flush | input | 1 | Flush instruction at sandbox entry |
| evt_mispredict | input | 1 | Branch misprediction |
| clr_on_misspec | input | 1 | Per-process control: flush on misprediction |
| cur_epoch | output | 2 | Current flush epoch |
| wt_valid | output | 1 | Write-through to the L1 |
| wt_paddr | output | 32 | Line-aligned write-through address |
| wt_data | output | 512 | Written-through line |
| rereq_valid | output | 1 | Re-request of an evicted committed line |
| rereq_paddr | output | 32 | Line-aligned re-request address |
| pf_valid | output | 1 | Prefetch notification |
| pf_level | output | 2 | Level receiving the notification |

## Verification
The bound checker enforces the following on every cycle:
- L1 traffic is caused only by a commit in the previous cycle.
- Write-through and re-request never coincide.
- Every prefetch notice rides on a write-through to a level enabled in the mask.
- Every flush advances the epoch, and a lookup just after a flush, or during one, misses.

Other properties depend on which lines are resident, so only the directed scenarios can show them:
- round-robin victim order;
- alias replacement;
- the committed flag surviving residency, so that a second commit is silent;
- discard of stale-epoch fills;
- the same-cycle fill/commit resolution.

// File: rtl/l0f_pkg.sv
package l0f_pkg;

  // Code of the hierarchy level that supplied a line.
  typedef enum logic [1:0] {
    SRC_L1  = 2'd0,
    SRC_L2  = 2'd1,
    SRC_L3  = 2'd2,
    SRC_MEM = 2'd3
  } src_lvl_e;

  // True when the given source level owns a prefetcher.
  function automatic logic level_prefetches(input logic [3:0] mask, input src_lvl_e lvl);
    return mask[lvl];
  endfunction

endpackage

// File: rtl/l0f_tags.sv
module l0f_tags #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [IDX_W-1:0]      lk_idx,
  input  logic [TAG_W-1:0]      lk_vtag,
  output logic [WAYS-1:0]       lk_match,
  input  logic [IDX_W-1:0]      cm_idx,
  input  logic [TAG_W-1:0]      cm_ptag,
  output logic [WAYS-1:0]       cm_match,
  output logic [WAYS-1:0]       cm_cmt,
  output logic [WAYS-1:0][1:0]  cm_src,
  input  logic [IDX_W-1:0]      fl_idx,
  input  logic [TAG_W-1:0]      fl_ptag,
  output logic [WAYS-1:0]       fl_match,
  output logic [WAYS-1:0]       fl_valid,
  input  logic                  set_cmt,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic [WAY_W-1:0]      set_way,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [TAG_W-1:0]      wr_vtag,
  input  logic [TAG_W-1:0]      wr_ptag,
  input  logic [1:0]            wr_src,
  input  logic                  wr_cmt
);

  // Valid bits live in their own flops so a flush is a single-cycle clear.
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  cmt_q   [SETS];
  logic [TAG_W-1:0] vtag_q  [SETS][WAYS];
  logic [TAG_W-1:0] ptag_q  [SETS][WAYS];
  logic [1:0]       src_q   [SETS][WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_match[w] = valid_q[lk_idx][w] && (vtag_q[lk_idx][w] == lk_vtag);
    assign cm_match[w] = valid_q[cm_idx][w] && (ptag_q[cm_idx][w] == cm_ptag);
    assign cm_cmt[w]   = cmt_q[cm_idx][w];
    assign cm_src[w]   = src_q[cm_idx][w];
    assign fl_match[w] = valid_q[fl_idx][w] && (ptag_q[fl_idx][w] == fl_ptag);
    assign fl_valid[w] = valid_q[fl_idx][w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  // Payload needs no reset: it is only read behind a set valid bit.
  always_ff @(posedge clk) begin
    if (set_cmt) cmt_q[set_idx][set_way] <= 1'b1;
    if (wr_en) begin
      cmt_q[wr_idx][wr_way]  <= wr_cmt;
      vtag_q[wr_idx][wr_way] <= wr_vtag;
      ptag_q[wr_idx][wr_way] <= wr_ptag;
      src_q[wr_idx][wr_way]  <= wr_src;
    end
  end

endmodule

// File: rtl/l0f_victim.sv
module l0f_victim #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAYS-1:0]  match_vec,
  input  logic             take,
  output logic [WAY_W-1:0] way
);

  logic [WAY_W-1:0] rr_q [SETS];
  logic             use_rr;

  function automatic logic [WAY_W-1:0] lowest_free(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (!v[w]) r = WAY_W'(w);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] encode(input logic [WAYS-1:0] oh);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (oh[w]) r = r | WAY_W'(w);
    return r;
  endfunction

  assign use_rr = !(|match_vec) && (&valid_vec);
  assign way    = (|match_vec) ? encode(match_vec)
                : (use_rr ? rr_q[idx] : lowest_free(valid_vec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (take && use_rr) begin
      rr_q[idx] <= rr_q[idx] + WAY_W'(1);
    end
  end

endmodule

// File: rtl/l0f_data.sv
module l0f_data #(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int DEPTH = SETS * WAYS
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WAY_W-1:0]  w_way,
  input  logic [LINE_W-1:0] w_data,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [WAY_W-1:0]  ra_way,
  output logic [LINE_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [WAY_W-1:0]  rb_way,
  output logic [LINE_W-1:0] rb_data
);

  logic [LINE_W-1:0] mem_q [DEPTH];

  function automatic logic [IDX_W+WAY_W-1:0] slot(input logic [IDX_W-1:0] i,
                                                 input logic [WAY_W-1:0] w);
    return {i, w};
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem_q[slot(w_idx, w_way)] <= w_data;
  end

  assign ra_data = mem_q[slot(ra_idx, ra_way)];
  assign rb_data = mem_q[slot(rb_idx, rb_way)];

endmodule

// File: rtl/l0f_filter_cache.sv
module l0f_filter_cache
  import l0f_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          LINE_BYTES = 64,
  parameter int          LINES      = 32,
  parameter int          WAYS       = 4,
  parameter int          EPOCH_W    = 2,
  parameter logic [3:0]  PF_MASK    = 4'b0011,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_vaddr,
  output logic               lk_hit,
  output logic [LINE_W-1:0]  lk_data,
  input  logic               fill_valid,
  input  logic [ADDR_W-1:0]  fill_vaddr,
  input  logic [ADDR_W-1:0]  fill_paddr,
  input  logic               fill_spec,
  input  logic [1:0]         fill_src,
  input  logic [EPOCH_W-1:0] fill_epoch,
  input  logic [LINE_W-1:0]  fill_data,
  input  logic               cm_valid,
  input  logic [ADDR_W-1:0]  cm_paddr,
  input  logic               evt_ctx_switch,
  input  logic               evt_syscall,
  input  logic               evt_domain_switch,
  input  logic               evt_sandbox_flush,
  input  logic               evt_mispredict,
  input  logic               clr_on_misspec,
  output logic [EPOCH_W-1:0] cur_epoch,
  output logic               wt_valid,
  output logic [ADDR_W-1:0]  wt_paddr,
  output logic [LINE_W-1:0]  wt_data,
  output logic               rereq_valid,
  output logic [ADDR_W-1:0]  rereq_paddr,
  output logic               pf_valid,
  output logic [1:0]         pf_level
);

  localparam int SETS  = LINES / WAYS;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [WAY_W-1:0] way_of(input logic [WAYS-1:0] oh);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (oh[w]) r = r | WAY_W'(w);
    return r;
  endfunction

  // Named internal events, visible to the bound checker.
  logic               flush_now;
  logic               fill_take;
  logic               cm_hit;
  logic               cm_first;
  logic               cm_same_fill;
  logic [EPOCH_W-1:0] epoch_q;

  logic [WAYS-1:0]      lk_match, cm_match, cm_cmt, fl_match, fl_valid;
  logic [WAYS-1:0][1:0] cm_src;
  logic [WAY_W-1:0]     cm_way, fl_way;
  logic [LINE_W-1:0]    lk_rd, cm_rd;
  src_lvl_e             cm_lvl;

  assign flush_now = evt_ctx_switch | evt_syscall | evt_domain_switch | evt_sandbox_flush
                   | (evt_mispredict & clr_on_misspec);
  assign fill_take = fill_valid && !flush_now && (fill_epoch == epoch_q);

  assign cm_hit       = |cm_match;
  assign cm_way       = way_of(cm_match);
  assign cm_first     = cm_valid && cm_hit && !cm_cmt[cm_way];
  assign cm_same_fill = cm_valid && fill_take &&
                        (line_base(cm_paddr) == line_base(fill_paddr));
  assign cm_lvl       = src_lvl_e'(cm_src[cm_way]);

  l0f_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_now),
    .lk_idx   (idx_of(lk_vaddr)),
    .lk_vtag  (tag_of(lk_vaddr)),
    .lk_match (lk_match),
    .cm_idx   (idx_of(cm_paddr)),
    .cm_ptag  (tag_of(cm_paddr)),
    .cm_match (cm_match),
    .cm_cmt   (cm_cmt),
    .cm_src   (cm_src),
    .fl_idx   (idx_of(fill_paddr)),
    .fl_ptag  (tag_of(fill_paddr)),
    .fl_match (fl_match),
    .fl_valid (fl_valid),
    .set_cmt  (cm_first),
    .set_idx  (idx_of(cm_paddr)),
    .set_way  (cm_way),
    .wr_en    (fill_take),
    .wr_idx   (idx_of(fill_paddr)),
    .wr_way   (fl_way),
    .wr_vtag  (tag_of(fill_vaddr)),
    .wr_ptag  (tag_of(fill_paddr)),
    .wr_src   (fill_src),
    .wr_cmt   (!fill_spec || cm_same_fill)
  );

  l0f_victim #(.WAYS(WAYS), .SETS(SETS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx_of(fill_paddr)),
    .valid_vec (fl_valid),
    .match_vec (fl_match),
    .take      (fill_take),
    .way       (fl_way)
  );

  l0f_data #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .we      (fill_take),
    .w_idx   (idx_of(fill_paddr)),
    .w_way   (fl_way),
    .w_data  (fill_data),
    .ra_idx  (idx_of(lk_vaddr)),
    .ra_way  (way_of(lk_match)),
    .ra_data (lk_rd),
    .rb_idx  (idx_of(cm_paddr)),
    .rb_way  (cm_way),
    .rb_data (cm_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epoch_q     <= '0;
      lk_hit      <= 1'b0;
      lk_data     <= '0;
      wt_valid    <= 1'b0;
      wt_paddr    <= '0;
      wt_data     <= '0;
      rereq_valid <= 1'b0;
      rereq_paddr <= '0;
      pf_valid    <= 1'b0;
      pf_level    <= '0;
    end else begin
      if (flush_now) epoch_q <= epoch_q + EPOCH_W'(1);
      lk_hit      <= lk_valid && (|lk_match) && !flush_now;
      lk_data     <= lk_rd;
      wt_valid    <= cm_first;
      wt_paddr    <= line_base(cm_paddr);
      wt_data     <= cm_rd;
      rereq_valid <= cm_valid && !cm_hit;
      rereq_paddr <= line_base(cm_paddr);
      pf_valid    <= cm_first && level_prefetches(PF_MASK, cm_lvl);
      pf_level    <= cm_src[cm_way];
    end
  end

  assign cur_epoch = epoch_q;

endmodule

// File: rtl/l0f_filter_cache_chk.sv
module l0f_filter_cache_chk #(
  parameter int         EPOCH_W = 2,
  parameter logic [3:0] PF_MASK = 4'b0011
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               cm_valid,
  input logic               cm_first,
  input logic               flush_now,
  input logic               evt_ctx_switch,
  input logic               evt_syscall,
  input logic               evt_domain_switch,
  input logic               evt_sandbox_flush,
  input logic               evt_mispredict,
  input logic               clr_on_misspec,
  input logic [EPOCH_W-1:0] cur_epoch,
  input logic               wt_valid,
  input logic               rereq_valid,
  input logic               pf_valid,
  input logic [1:0]         pf_level
);

  logic any_domain_evt;
  assign any_domain_evt = evt_ctx_switch | evt_syscall | evt_domain_switch | evt_sandbox_flush;

  assert_hit_follows_lookup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));

  assert_wt_follows_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> $past(cm_valid));

  assert_first_commit_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_first |=> wt_valid);

  assert_rereq_excludes_wt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rereq_valid |-> ($past(cm_valid) && !wt_valid));

  assert_domain_evt_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(any_domain_evt) && lk_valid) |=> !lk_hit);

  assert_mispredict_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mispredict && !clr_on_misspec && !any_domain_evt) |=> $stable(cur_epoch));

  assert_pf_rides_wt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (wt_valid && PF_MASK[pf_level]));

  assert_epoch_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (cur_epoch == EPOCH_W'($past(cur_epoch) + EPOCH_W'(1))));

  assert_no_hit_in_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && any_domain_evt) |=> !lk_hit);

endmodule

bind l0f_filter_cache l0f_filter_cache_chk #(.EPOCH_W(EPOCH_W), .PF_MASK(PF_MASK)) u_chk (.*);

// File: tb/tb_l0f_filter_cache.sv
`timescale 1ns/1ps
module tb_l0f_filter_cache;

  localparam int AW = 32;
  localparam int LW = 512;
  localparam int EW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid, fill_valid, fill_spec, cm_valid;
  logic [AW-1:0] lk_vaddr, fill_vaddr, fill_paddr, cm_paddr;
  logic [1:0]    fill_src;
  logic [EW-1:0] fill_epoch;
  logic [LW-1:0] fill_data;
  logic          evt_ctx_switch, evt_syscall, evt_domain_switch, evt_sandbox_flush;
  logic          evt_mispredict, clr_on_misspec;
  logic          lk_hit, wt_valid, rereq_valid, pf_valid;
  logic [LW-1:0] lk_data, wt_data;
  logic [EW-1:0] cur_epoch;
  logic [AW-1:0] wt_paddr, rereq_paddr;
  logic [1:0]    pf_level;

  always #4 clk = ~clk;  // 125 MHz

  l0f_filter_cache dut (.*);

  int            n_chk = 0;
  int            n_bad = 0;
  logic [EW-1:0] ep_m = '0;

  function automatic logic [AW-1:0] va_of(int t, int s);
    return {23'(32'h4000 + t), 3'(s), 6'h00};
  endfunction
  function automatic logic [AW-1:0] pa_of(int t, int s);
    return {23'(32'h1200 + t), 3'(s), 6'h00};
  endfunction
  function automatic logic [LW-1:0] pat(logic [AW-1:0] pa);
    return {16{pa ^ 32'hC3A5_0000}};
  endfunction

  task automatic chk(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; cm_valid = 0;
    evt_ctx_switch = 0; evt_syscall = 0; evt_domain_switch = 0;
    evt_sandbox_flush = 0; evt_mispredict = 0;
  endtask

  task automatic set_fill(logic [AW-1:0] va, logic [AW-1:0] pa, logic sp,
                          logic [1:0] src, logic [EW-1:0] ep);
    fill_valid = 1; fill_vaddr = va; fill_paddr = pa; fill_spec = sp;
    fill_src = src; fill_epoch = ep; fill_data = pat(pa);
  endtask

  task automatic fill(logic [AW-1:0] va, logic [AW-1:0] pa, logic sp, logic [1:0] src);
    @(negedge clk); set_fill(va, pa, sp, src, ep_m);
    @(negedge clk); idle();
  endtask

  task automatic lookup(logic [AW-1:0] va);
    @(negedge clk); lk_valid = 1; lk_vaddr = va;
    @(negedge clk); idle();
  endtask

  task automatic commit(logic [AW-1:0] pa);
    @(negedge clk); cm_valid = 1; cm_paddr = pa;
    @(negedge clk); idle();
  endtask

  task automatic raise_evt(int k);
    case (k)
      0: evt_ctx_switch = 1;
      1: evt_syscall = 1;
      2: evt_domain_switch = 1;
      default: evt_sandbox_flush = 1;
    endcase
    ep_m = ep_m + EW'(1);
  endtask

  task automatic flush_ev(int k);
    @(negedge clk); raise_evt(k);
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1", "lk_hit after reset", LW'(lk_hit), '0);
    chk("R3", "wt_valid after reset", LW'(wt_valid), '0);
    chk("R4", "rereq_valid after reset", LW'(rereq_valid), '0);
    chk("R9", "pf_valid after reset", LW'(pf_valid), '0);
    chk("R10", "epoch after reset", LW'(cur_epoch), '0);
  endtask

  task automatic t_fill_lookup();
    fill(va_of(1, 2), pa_of(1, 2), 1'b1, 2'd1);
    lookup(va_of(1, 2) + 32'h14);
    chk("R1", "hit on resident line", LW'(lk_hit), LW'(1));
    chk("R1", "line data", lk_data, pat(pa_of(1, 2)));
    lookup(va_of(9, 2));
    chk("R1", "other tag misses", LW'(lk_hit), '0);
  endtask

  task automatic t_commit_spec();
    commit(pa_of(1, 2) + 32'h08);
    chk("R3", "write-through on first commit", LW'(wt_valid), LW'(1));
    chk("R3", "write-through address", LW'(wt_paddr), LW'(pa_of(1, 2)));
    chk("R3", "write-through data", wt_data, pat(pa_of(1, 2)));
    chk("R9", "prefetch notice for L2", LW'(pf_valid), LW'(1));
    chk("R9", "prefetch level", LW'(pf_level), LW'(1));
    lookup(va_of(1, 2));
    chk("R3", "line stays resident", LW'(lk_hit), LW'(1));
    commit(pa_of(1, 2));
    chk("R3", "second commit silent wt", LW'(wt_valid), '0);
    chk("R3", "second commit silent rereq", LW'(rereq_valid), '0);
  endtask

  task automatic t_nonspec();
    fill(va_of(2, 3), pa_of(2, 3), 1'b0, 2'd1);
    commit(pa_of(2, 3));
    chk("R2", "non-speculative line no wt", LW'(wt_valid), '0);
    chk("R2", "non-speculative line no rereq", LW'(rereq_valid), '0);
  endtask

  task automatic t_absent();
    commit(pa_of(3, 4) + 32'h3C);
    chk("R4", "absent line re-request", LW'(rereq_valid), LW'(1));
    chk("R4", "re-request address", LW'(rereq_paddr), LW'(pa_of(3, 4)));
    chk("R4", "absent line no wt", LW'(wt_valid), '0);
  endtask

  task automatic t_pf_mask();
    fill(va_of(4, 5), pa_of(4, 5), 1'b1, 2'd3);
    commit(pa_of(4, 5));
    chk("R9", "memory-sourced line writes through", LW'(wt_valid), LW'(1));
    chk("R9", "no notice to memory", LW'(pf_valid), '0);
    fill(va_of(5, 5), pa_of(5, 5), 1'b1, 2'd0);
    commit(pa_of(5, 5));
    chk("R9", "notice to L1", LW'(pf_valid), LW'(1));
    chk("R9", "L1 level code", LW'(pf_level), '0);
    fill(va_of(6, 5), pa_of(6, 5), 1'b1, 2'd2);
    commit(pa_of(6, 5));
    chk("R9", "no notice to L3", LW'(pf_valid), '0);
  endtask

  task automatic t_evict();
    for (int i = 0; i < 5; i++) begin
      fill(va_of(50 + i, 7), pa_of(50 + i, 7), 1'b1, 2'd1);
      chk("R5", "eviction emits no wt", LW'(wt_valid), '0);
    end
    lookup(va_of(50, 7));
    chk("R5", "way 0 victim gone", LW'(lk_hit), '0);
    lookup(va_of(51, 7));
    chk("R5", "way 1 kept", LW'(lk_hit), LW'(1));
    commit(pa_of(50, 7));
    chk("R5", "evicted uncommitted line re-requested", LW'(rereq_valid), LW'(1));
    chk("R5", "evicted line not written", LW'(wt_valid), '0);
    fill(va_of(55, 7), pa_of(55, 7), 1'b1, 2'd1);
    lookup(va_of(51, 7));
    chk("R5", "round-robin hits way 1 next", LW'(lk_hit), '0);
    lookup(va_of(52, 7));
    chk("R5", "way 2 kept", LW'(lk_hit), LW'(1));
  endtask

  task automatic t_alias();
    fill(va_of(60, 6), pa_of(60, 6), 1'b1, 2'd1);
    fill(va_of(61, 6), pa_of(60, 6), 1'b1, 2'd1);
    lookup(va_of(60, 6));
    chk("R8", "old alias misses", LW'(lk_hit), '0);
    lookup(va_of(61, 6));
    chk("R8", "new alias hits", LW'(lk_hit), LW'(1));
    chk("R8", "new alias data", lk_data, pat(pa_of(60, 6)));
    for (int i = 0; i < 3; i++) fill(va_of(62 + i, 6), pa_of(62 + i, 6), 1'b1, 2'd1);
    lookup(va_of(61, 6));
    chk("R8", "single copy keeps room", LW'(lk_hit), LW'(1));
  endtask

  task automatic t_flush_events();
    for (int k = 0; k < 4; k++) begin
      fill(va_of(70 + k, 1), pa_of(70 + k, 1), 1'b1, 2'd1);
      flush_ev(k);
      lookup(va_of(70 + k, 1));
      chk("R6", $sformatf("flush kind %0d clears line", k), LW'(lk_hit), '0);
      chk("R10", "epoch after flush", LW'(cur_epoch), LW'(ep_m));
    end
    lookup(va_of(1, 2));
    chk("R6", "earlier lines cleared", LW'(lk_hit), '0);
  endtask

  task automatic t_mispredict();
    fill(va_of(80, 0), pa_of(80, 0), 1'b1, 2'd1);
    @(negedge clk); evt_mispredict = 1; clr_on_misspec = 0;
    @(negedge clk); idle();
    lookup(va_of(80, 0));
    chk("R7", "mispredict without control keeps line", LW'(lk_hit), LW'(1));
    chk("R7", "epoch unchanged", LW'(cur_epoch), LW'(ep_m));
    @(negedge clk); evt_mispredict = 1; clr_on_misspec = 1; ep_m = ep_m + EW'(1);
    @(negedge clk); idle(); clr_on_misspec = 0;
    lookup(va_of(80, 0));
    chk("R7", "mispredict with control flushes", LW'(lk_hit), '0);
  endtask

  task automatic t_stale_epoch();
    logic [EW-1:0] old;
    old = ep_m;
    flush_ev(1);
    @(negedge clk); set_fill(va_of(81, 0), pa_of(81, 0), 1'b1, 2'd1, old);
    @(negedge clk); idle();
    lookup(va_of(81, 0));
    chk("R10", "stale-epoch fill discarded", LW'(lk_hit), '0);
    @(negedge clk); set_fill(va_of(82, 0), pa_of(82, 0), 1'b1, 2'd1, ep_m); raise_evt(0);
    @(negedge clk); idle();
    lookup(va_of(82, 0));
    chk("R10", "fill during flush discarded", LW'(lk_hit), '0);
    fill(va_of(83, 0), pa_of(83, 0), 1'b1, 2'd1);
    lookup(va_of(83, 0));
    chk("R10", "current-epoch fill kept", LW'(lk_hit), LW'(1));
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    set_fill(va_of(90, 3), pa_of(90, 3), 1'b1, 2'd1, ep_m);
    cm_valid = 1; cm_paddr = pa_of(90, 3);
    @(negedge clk); idle();
    chk("R11", "commit sees pre-fill state", LW'(rereq_valid), LW'(1));
    chk("R11", "no wt for absent line", LW'(wt_valid), '0);
    commit(pa_of(90, 3));
    chk("R11", "line installed committed", LW'(wt_valid), '0);
    lookup(va_of(90, 3));
    chk("R11", "line resident", LW'(lk_hit), LW'(1));
  endtask

  task automatic t_lookup_in_flush();
    fill(va_of(91, 4), pa_of(91, 4), 1'b1, 2'd1);
    @(negedge clk); lk_valid = 1; lk_vaddr = va_of(91, 4); raise_evt(2);
    @(negedge clk); idle();
    chk("R12", "lookup during flush misses", LW'(lk_hit), '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    clr_on_misspec = 0; lk_vaddr = '0; cm_paddr = '0;
    fill_vaddr = '0; fill_paddr = '0; fill_spec = 0; fill_src = '0;
    fill_epoch = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_lookup();
    t_commit_spec();
    t_nonspec();
    t_absent();
    t_pf_mask();
    t_evict();
    t_alias();
    t_flush_events();
    t_mispredict();
    t_stale_epoch();
    t_same_cycle();
    t_lookup_in_flush();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule